// File: doc/BRIEF.md
# Chip-Select Access Timing Sequencer

This block drives the strobes for one external memory region behind a chip select. A simple request port hands it a read or a write with an address, write data, byte lanes and, for reads, a beat count. The block then walks the external pins through the phases of the access: an optional setup cycle, the access strobe with its programmed wait states, an optional stretch from an external wait input, and hold cycles. A multi-beat read can skip the hold cycles between its beats while keeping the hold at the end.

The timing comes from a 32-bit configuration word. Software writes it at any time. The sequencer copies the word when it accepts a request, so a write that lands mid-transaction applies from the next request onwards. Requests that the region must refuse finish at once with a one-cycle error pulse and drive no strobes. A region is refused when it is disabled, or when it gets a partial-lane write while byte lanes are off.

Top module: `cs_timing_seq`

## Requirements
- R1: After reset the configuration reads 0x0000000F (wait count 15, all else 0). Chip select, output enable, write enable and byte enables are inactive, and the request port is ready.
- R2: Configuration fields are: wait count at bits 3:0, hold count at bits 5:4, setup at bit 7, wait-input enable at bit 8, hold-disable at bit 10, region enable at bit 12, byte-lane use at bit 13. All other bits read back as 0.
- R3: A request while bit 12 is 0 gives `err_o` high for exactly the cycle after acceptance. It drives no strobe and no `done_o`.
- R4: With bit 7 set, the transaction opens with one cycle in which address and the read/write strobe are driven and chip select is low. Chip select asserts in the next cycle.
- R5: Each beat holds chip select and its direction strobe (`mem_oe_o` for reads, `mem_we_o` for writes) high for 1 + wait count cycles, unless the wait input stretches it.
- R6: After a beat, hold-count cycles follow with all strobes low and the address held.
- R7: With bit 10 set, the beats of a multi-beat read follow each other with no hold between them. The hold after the final beat is still inserted.
- R8: The wait input passes through a two-flop synchroniser. With bit 8 set, each synchronised high sample once the wait count has run out adds one access cycle. With bit 8 clear, the input has no effect on timing.
- R9: With bit 13 set, `mem_be_o` carries the request's lanes (bit 0 low byte, bit 1 high byte, 1 = active) while a strobe is high. Otherwise it is 00. A write whose lanes are not 11 while bit 13 is 0 is refused like R3.
- R10: Read data is sampled on the last access cycle of each beat. It appears on `rdata_o` with a one-cycle `done_o` in the following cycle. `last_o` is raised with the `done_o` of the final beat.
- R11: `req_ready_o` is high only in idle. A configuration write during a transaction does not alter that transaction and applies to the next one.
- R12: A read runs `req_len_i`+1 beats, with the address stepping by 1 per beat. A write always runs one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write word |
| cfg_o | output | 32 | Configuration read-back |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Start address |
| req_wdata_i | input | DATA_W | Write data |
| req_be_i | input | DATA_W/8 | Byte lanes of the request |
| req_len_i | input | LEN_W | Read beats minus one |
| done_o | output | 1 | Beat complete pulse |
| last_o | output | 1 | Final beat marker with done |
| err_o | output | 1 | Refused request pulse |
| rdata_o | output | DATA_W | Captured read data |
| mem_cs_o | output | 1 | Chip select, active high |
| mem_oe_o | output | 1 | Output enable, active high |
| mem_we_o | output | 1 | Write enable, active high |
| mem_be_o | output | DATA_W/8 | Byte enables, active high |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_wait_i | input | 1 | External wait, asynchronous |

## Verification
The bound checker covers the rules that need no cycle counting, on every cycle. Reserved bits read as zero. A refusal pulse never coincides with a strobe. Chip select always comes with exactly one direction strobe. Byte enables are quiet outside strobes. The port is never ready while a strobe is out. Done only follows chip select, and chip select only falls as a beat completes. The exact phase lengths need the bench's trace model, which predicts every cycle's pins: setup, wait count, wait stretch two cycles behind the input, hold, skipped inter-beat hold, beat addresses and read data. So do the latching of configuration at acceptance and the ignoring of the wait input.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;
  typedef struct packed {
    logic       ube;
    logic       ena;
    logic       hd;
    logic       wt;
    logic       set;
    logic [1:0] hs;
    logic [3:0] ws;
  } cs_cfg_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACCESS, PH_HOLD} phase_e;

  localparam logic [31:0] CFG_RST_WORD = 32'h0000_000F;

  function automatic cs_cfg_t cfg_unpack(logic [31:0] w);
    cs_cfg_t c;
    c.ws  = w[3:0];
    c.hs  = w[5:4];
    c.set = w[7];
    c.wt  = w[8];
    c.hd  = w[10];
    c.ena = w[12];
    c.ube = w[13];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(cs_cfg_t c);
    logic [31:0] w;
    w      = '0;
    w[3:0] = c.ws;
    w[5:4] = c.hs;
    w[7]   = c.set;
    w[8]   = c.wt;
    w[10]  = c.hd;
    w[12]  = c.ena;
    w[13]  = c.ube;
    return w;
  endfunction
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg
  import cs_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output cs_cfg_t     cfg_o,
  output logic [31:0] word_o
);
  cs_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= cfg_unpack(CFG_RST_WORD);
    else if (we_i) cfg_q <= cfg_unpack(wdata_i);
  end

  assign cfg_o  = cfg_q;
  assign word_o = cfg_pack(cfg_q);
endmodule

// File: rtl/cs_sync2.sv
module cs_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/cs_phase_fsm.sv
module cs_phase_fsm
  import cs_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 2,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cs_cfg_t           cfg_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              wait_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output phase_e            phase_o,
  output logic              write_o,
  output logic              ube_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BE_W-1:0]   be_o,
  output logic              done_o,
  output logic              last_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o
);
  phase_e            phase_q;
  cs_cfg_t           act_q;
  logic              wr_q, done_q, last_q, err_q;
  logic [3:0]        cnt_q;
  logic [LEN_W-1:0]  beat_q, len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [BE_W-1:0]   be_q;

  logic refuse, more_beats;
  assign refuse     = !cfg_i.ena || (req_write_i && (req_be_i != '1) && !cfg_i.ube);
  assign more_beats = (beat_q != len_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      act_q   <= cfg_unpack(CFG_RST_WORD);
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      beat_q  <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      last_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (req_valid_i) begin
          if (refuse) err_q <= 1'b1;
          else begin
            act_q   <= cfg_i;
            wr_q    <= req_write_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            be_q    <= req_be_i;
            len_q   <= req_write_i ? '0 : req_len_i;
            beat_q  <= '0;
            cnt_q   <= cfg_i.ws;
            phase_q <= cfg_i.set ? PH_SETUP : PH_ACCESS;
          end
        end
        PH_SETUP: phase_q <= PH_ACCESS;
        PH_ACCESS: begin
          if (cnt_q != 0) cnt_q <= cnt_q - 4'd1;
          else if (!(act_q.wt && wait_i)) begin
            done_q <= 1'b1;
            last_q <= !more_beats;
            if (!wr_q) rdata_q <= mem_rdata_i;
            if (more_beats && (act_q.hd || act_q.hs == 0)) begin
              beat_q <= beat_q + 1'b1;
              addr_q <= addr_q + 1'b1;
              cnt_q  <= act_q.ws;
            end else if (act_q.hs != 0) begin
              phase_q <= PH_HOLD;
              cnt_q   <= 4'(act_q.hs) - 4'd1;
            end else begin
              phase_q <= PH_IDLE;
            end
          end
        end
        PH_HOLD: begin
          if (cnt_q != 0) cnt_q <= cnt_q - 4'd1;
          else if (more_beats) begin
            phase_q <= PH_ACCESS;
            beat_q  <= beat_q + 1'b1;
            addr_q  <= addr_q + 1'b1;
            cnt_q   <= act_q.ws;
          end else begin
            phase_q <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign write_o = wr_q;
  assign ube_o   = act_q.ube;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign be_o    = be_q;
  assign done_o  = done_q;
  assign last_o  = last_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/cs_timing_seq.sv
module cs_timing_seq
  import cs_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 2,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              done_o,
  output logic              last_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_cs_o,
  output logic              mem_oe_o,
  output logic              mem_we_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_wait_i
);
  cs_cfg_t         cfg;
  phase_e          phase;
  logic            wait_s, wr, ube, strobe;
  logic [BE_W-1:0] be;

  cs_cfg_reg u_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .cfg_o(cfg), .word_o(cfg_o)
  );

  cs_sync2 #(.STAGES(2)) u_wait_sync (
    .clk_i, .rst_ni, .d_i(mem_wait_i), .q_o(wait_s)
  );

  cs_phase_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
    .clk_i, .rst_ni, .cfg_i(cfg),
    .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i, .req_be_i, .req_len_i,
    .wait_i(wait_s), .mem_rdata_i,
    .phase_o(phase), .write_o(wr), .ube_o(ube), .addr_o(mem_addr_o),
    .wdata_o(mem_wdata_o), .be_o(be), .done_o, .last_o, .err_o, .rdata_o
  );

  assign strobe      = (phase == PH_SETUP) || (phase == PH_ACCESS);
  assign mem_cs_o    = (phase == PH_ACCESS);
  assign mem_oe_o    = strobe && !wr;
  assign mem_we_o    = strobe && wr;
  assign mem_be_o    = (strobe && ube) ? be : '0;
  assign req_ready_o = (phase == PH_IDLE);
endmodule

// File: rtl/cs_timing_seq_chk.sv
module cs_timing_seq_chk #(
  parameter int BE_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [31:0]     cfg_o,
  input logic            req_ready_o,
  input logic            mem_cs_o,
  input logic            mem_oe_o,
  input logic            mem_we_o,
  input logic [BE_W-1:0] mem_be_o,
  input logic            done_o,
  input logic            last_o,
  input logic            err_o
);
  localparam logic [31:0] LIVE_BITS = 32'h0000_35BF;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o & ~LIVE_BITS) == 32'h0); // R2
  AST_ERR_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_cs_o && !mem_oe_o && !mem_we_o && !done_o); // R3
  AST_CS_ONE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs_o |-> (mem_oe_o != mem_we_o)); // R5
  AST_CS_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_cs_o) |-> done_o); // R6
  AST_BE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_oe_o || mem_we_o) |-> mem_be_o == '0); // R9
  AST_DONE_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_cs_o)); // R10
  AST_LAST_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> done_o); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cs_o || mem_oe_o || mem_we_o) |-> !req_ready_o); // R11
endmodule

bind cs_timing_seq cs_timing_seq_chk #(.BE_W(BE_W)) u_chk (
  .clk_i, .rst_ni, .cfg_o, .req_ready_o, .mem_cs_o, .mem_oe_o, .mem_we_o,
  .mem_be_o, .done_o, .last_o, .err_o
);

// File: tb/cs_timing_seq_tb_top.sv
module cs_timing_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 2;

  typedef struct {
    bit cs, oe, we, done, last, err, ready, wt, chk_addr, chk_wd, chk_rd;
    bit [1:0] be;
    int addr, wdata, rdata;
    string tag;
  } exp_t;

  logic clk_i = 0, rst_ni = 0;
  logic cfg_we_i = 0;
  logic [31:0] cfg_wdata_i = '0, cfg_o;
  logic req_valid_i = 0, req_ready_o, req_write_i = 0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic [1:0] req_be_i = '0;
  logic [LEN_W-1:0] req_len_i = '0;
  logic done_o, last_o, err_o, mem_cs_o, mem_oe_o, mem_we_o, mem_wait_i = 0;
  logic [DATA_W-1:0] rdata_o, mem_wdata_o, mem_rdata_i;
  logic [1:0] mem_be_o;
  logic [ADDR_W-1:0] mem_addr_o;

  int checks = 0, errors = 0;
  bit running = 0, finished = 0, force_wait = 0;
  exp_t q[$];
  int m_ws = 15, m_hs = 0;
  bit m_set = 0, m_wt = 0, m_hd = 0, m_ena = 0, m_ube = 0;
  int b_k, b_c, b_x, b_rd;
  bit b_pd, b_pl, b_prc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  assign mem_rdata_i = mem_addr_o ^ 16'h5A3C;

  cs_timing_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) dut_i (.*);

  task automatic chk(bit ok, string tag, int act, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp_v);
    end
  endtask

  // per-cycle comparison against the trace model
  always @(negedge clk_i) if (running) begin
    exp_t e;
    bit [8:0] av, ev;
    if (q.size() > 0) e = q.pop_front();
    else begin
      e = '{default: 0};
      e.ready = 1; e.wt = force_wait; e.tag = "R1";
    end
    mem_wait_i <= e.wt;
    av = {mem_cs_o, mem_oe_o, mem_we_o, mem_be_o, done_o, last_o, err_o, req_ready_o};
    ev = {e.cs, e.oe, e.we, e.be, e.done, e.last, e.err, e.ready};
    chk(av == ev, e.tag, int'(av), int'(ev));
    if (e.chk_addr) chk(mem_addr_o == e.addr[ADDR_W-1:0], e.tag, int'(mem_addr_o), e.addr);
    if (e.chk_wd) chk(mem_wdata_o == e.wdata[DATA_W-1:0], e.tag, int'(mem_wdata_o), e.wdata);
    if (e.chk_rd) chk(rdata_o == e.rdata[DATA_W-1:0], "R10", int'(rdata_o), e.rdata);
  end

  task automatic push(bit cs, bit oe, bit we, bit [1:0] be, bit ready, bit ca, int addr,
                      bit cw, int wd, string tag);
    exp_t e;
    e = '{default: 0};
    e.cs = cs; e.oe = oe; e.we = we; e.be = be; e.ready = ready;
    e.chk_addr = ca; e.addr = addr & 16'hFFFF; e.chk_wd = cw; e.wdata = wd; e.tag = tag;
    e.wt = force_wait || (m_wt && b_k >= b_c - 2 && b_k < b_c - 2 + b_x);
    if (b_pd) begin
      e.done = 1; e.last = b_pl; e.chk_rd = b_prc; e.rdata = b_rd;
      b_pd = 0;
    end
    b_k++;
    q.push_back(e);
  endtask

  task automatic build(bit wr, int addr, bit [1:0] be, int wd, int nb, int x, string tag);
    bit [1:0] ebe;
    exp_t e;
    if (!m_ena || (wr && be != 2'b11 && !m_ube)) begin
      e = '{default: 0};
      e.err = 1; e.ready = 1; e.wt = force_wait; e.tag = tag;
      q.push_back(e);
      return;
    end
    if (wr) nb = 1;
    ebe = m_ube ? be : 2'b00;
    b_k = 0; b_c = m_set + m_ws; b_x = x; b_pd = 0;
    if (m_set) push(0, !wr, wr, ebe, 0, 1, addr, wr, wd, tag);
    for (int b = 0; b < nb; b++) begin
      for (int i = 0; i < 1 + m_ws + (b == 0 ? x : 0); i++)
        push(1, !wr, wr, ebe, 0, 1, addr + b, wr, wd, tag);
      b_pd = 1; b_pl = (b == nb - 1); b_prc = !wr; b_rd = ((addr + b) & 16'hFFFF) ^ 16'h5A3C;
      if (b < nb - 1 && m_hd) continue;
      for (int h = 0; h < m_hs; h++) push(0, 0, 0, 2'b00, 0, 1, addr + b, 0, 0, tag);
    end
    if (b_pd) push(0, 0, 0, 2'b00, 1, 0, 0, 0, 0, tag);
  endtask

  task automatic req(bit wr, int addr, bit [1:0] be, int wd, int nb, int x, string tag);
    @(negedge clk_i); #1;
    req_valid_i = 1; req_write_i = wr; req_addr_i = addr[ADDR_W-1:0];
    req_be_i = be; req_wdata_i = wd[DATA_W-1:0]; req_len_i = LEN_W'(nb - 1);
    build(wr, addr, be, wd, nb, x, tag);
    @(negedge clk_i); #1;
    req_valid_i = 0;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_cfg(int ws, int hs, bit set, bit wt, bit hd, bit ena, bit ube);
    @(negedge clk_i); #1;
    cfg_we_i = 1;
    cfg_wdata_i = 32'(ws & 15) | 32'((hs & 3) << 4) | (32'(set) << 7) | (32'(wt) << 8)
                | (32'(hd) << 10) | (32'(ena) << 12) | (32'(ube) << 13);
    @(negedge clk_i); #1;
    cfg_we_i = 0;
    m_ws = ws; m_hs = hs; m_set = set; m_wt = wt; m_hd = hd; m_ena = ena; m_ube = ube;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk(cfg_o == 32'h0000_000F, "R1", int'(cfg_o), 32'hF);
    running = 1;
    // R3: region disabled after reset
    req(0, 16'h0100, 2'b11, 0, 1, 0, "R3");
    drain();
    // R2: reserved bits read zero
    @(negedge clk_i); #1;
    cfg_we_i = 1; cfg_wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i); #1;
    cfg_we_i = 0;
    chk(cfg_o == 32'h0000_35BF, "R2", int'(cfg_o), 32'h35BF);
    m_ws = 15; m_hs = 3; m_set = 1; m_wt = 1; m_hd = 1; m_ena = 1; m_ube = 1;
    // R5 R6 R10: single read
    set_cfg(2, 1, 0, 0, 0, 1, 0);
    req(0, 16'h0200, 2'b11, 0, 1, 0, "R5");
    drain();
    // R4 R9 R12: setup, lanes driven, write forced single beat
    set_cfg(0, 0, 1, 0, 0, 1, 1);
    req(1, 16'h0300, 2'b01, 16'hBEEF, 3, 0, "R4");
    drain();
    // R9: byte write refused when lanes unused
    set_cfg(1, 1, 0, 0, 0, 1, 0);
    req(1, 16'h0310, 2'b10, 16'h1234, 1, 0, "R9");
    drain();
    // R9: full-width write accepted, lanes stay 00
    req(1, 16'h0320, 2'b11, 16'hC0DE, 1, 0, "R9");
    drain();
    // R12 R6: four beats with hold between
    set_cfg(1, 2, 0, 0, 0, 1, 1);
    req(0, 16'h0400, 2'b11, 0, 4, 0, "R12");
    drain();
    // R7: hold suppressed between beats, kept at the end
    set_cfg(0, 2, 0, 0, 1, 1, 0);
    req(0, 16'h0500, 2'b11, 0, 3, 0, "R7");
    drain();
    // R12: back-to-back beats with zero hold
    set_cfg(0, 0, 0, 0, 0, 1, 0);
    req(0, 16'hFFFE, 2'b11, 0, 3, 0, "R12");
    drain();
    // R8: external wait stretches by three
    set_cfg(3, 1, 0, 1, 0, 1, 0);
    req(0, 16'h0600, 2'b11, 0, 1, 3, "R8");
    drain();
    // R8: with setup, stretch of one
    set_cfg(2, 0, 1, 1, 0, 1, 0);
    req(0, 16'h0610, 2'b11, 0, 1, 1, "R8");
    drain();
    // R8: input ignored when disabled
    set_cfg(2, 1, 0, 0, 0, 1, 0);
    force_wait = 1;
    req(0, 16'h0700, 2'b11, 0, 2, 0, "R8");
    drain();
    force_wait = 0;
    // R11: configuration write mid-transaction
    set_cfg(5, 1, 0, 0, 0, 1, 0);
    req(0, 16'h0800, 2'b11, 0, 1, 0, "R11");
    set_cfg(0, 0, 1, 0, 0, 1, 0);
    drain();
    req(0, 16'h0810, 2'b11, 0, 1, 0, "R11");
    drain();
    // R3: disabled again
    set_cfg(1, 1, 0, 0, 0, 0, 1);
    req(1, 16'h0900, 2'b11, 16'h5555, 1, 0, "R3");
    drain();
    running = 0;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule